// File: doc/BRIEF.md
# DMA Request Event Scheduler

This block sits between peripheral request lines and a set of DMA channels. Each request line is level-sensitive, and a programmable table assigns it to a channel. A rising edge on a line activates the assigned channel: the channel is marked pending and a shared transfer engine moves one watermark-sized burst of words for it. Each word is a handshake (`xfer_valid_o` / `xfer_ack_i`). The engine serves one channel at a time. When several channels wait, it picks the highest channel number first.

The live request levels are exposed as a mirror. After every burst the engine re-reads the level of the lines mapped to the active channel. While that level is still high, it runs another burst, because a request that never fell produces no new edge to restart the channel. A channel finishes, and its pending flag clears, only when a burst ends with the level low.

A second rising edge for a channel that is still pending sets that channel's sticky error bit. An erroring channel is stalled: the engine abandons its burst and never grants it again until the error is cleared by a write-one-to-clear or the channel is reset. A per-channel mask chooses which error bits drive the interrupt output.

Top module: `dma_req_sched`

## Requirements
- R1: A channel is activated only by a 0-to-1 transition of a request line mapped to it. A line held high after its channel was reset does not activate the channel again.
- R2: Activation sets the channel's pending flag (`pend_o` bit = channel number). The flag clears when a burst of that channel ends while the mapped request level is low.
- R3: A rising edge for a channel whose pending flag is already set sets its error bit (`err_o` bit = channel number). The bit stays set until cleared.
- R4: Every burst moves exactly the channel's programmed watermark of words, one per cycle in which `xfer_valid_o` and `xfer_ack_i` are both high. A watermark of 0 behaves as 1. `burst_done_o` marks the last word of each burst.
- R5: `mirror_o` shows the request levels delayed by one clock. After each burst the engine starts another burst for the same channel while any request line mapped to it is high.
- R6: Request line r maps to channel r mod NUM_CH after reset. Command MAP (cfg_op=0, cfg_idx=line, cfg_data=channel) remaps it.
- R7: A channel with its error bit set receives no words. Its pending flag is kept. Command ERRCLR (cfg_op=3, cfg_data bit c = 1 clears channel c) removes the error, and the pending channel is then served.
- R8: `irq_o` is high exactly when some channel has its error bit and its mask bit both set. Command MASK (cfg_op=2, cfg_idx=channel, cfg_data[0]) writes the mask bit; masks reset to 0.
- R9: When several channels are pending and error-free, the highest channel number is served first, and a burst is never interrupted by another channel.
- R10: Command CHRST (cfg_op=4, cfg_data bit c = 1) clears pending and error of channel c and ends any burst in progress for it. Command WM (cfg_op=1, cfg_idx=channel, cfg_data) writes the watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | Peripheral request levels |
| cfg_we | input | 1 | Configuration command strobe |
| cfg_op | input | 3 | Command: 0 MAP, 1 WM, 2 MASK, 3 ERRCLR, 4 CHRST |
| cfg_idx | input | IDX_W | Line or channel index for MAP, WM, MASK |
| cfg_data | input | CFG_W | Command value or channel bit vector |
| mirror_o | output | NUM_REQ | Registered copy of request levels |
| pend_o | output | NUM_CH | Pending flags |
| err_o | output | NUM_CH | Sticky channel error bits |
| irq_o | output | 1 | Masked error interrupt |
| xfer_valid_o | output | 1 | Engine offers a word for the active channel |
| xfer_ch_o | output | CH_W | Active channel |
| xfer_ack_i | input | 1 | Word accepted |
| burst_done_o | output | 1 | Last word of a burst accepted |

## Verification
The bench builds the block with its defaults: four request lines, four channels and 4-bit watermarks. This covers every channel, both the identity map and a remapped line, and watermarks 0, 1, 2, 4 and 7 within one run. With four channels, two simultaneous requests can be made to meet in the arbiter. A held-low acknowledge freezes a burst long enough to inject a second edge, which reaches the error, stall and mask paths.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   typedef enum logic [2:0] {
      CFG_MAP    = 3'd0,
      CFG_WM     = 3'd1,
      CFG_MASK   = 3'd2,
      CFG_ERRCLR = 3'd3,
      CFG_CHRST  = 3'd4
   } cfg_op_e;
endpackage

// File: rtl/dreq_edge_map.sv
module dreq_edge_map #(
   parameter int NUM_REQ = 4,
   parameter int NUM_CH  = 4,
   parameter int CH_W    = 2,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_i,
   input  logic               map_wr,
   input  logic [IDX_W-1:0]   map_idx,
   input  logic [CH_W-1:0]    map_val,
   output logic [NUM_REQ-1:0] mirror_o,
   output logic [NUM_CH-1:0]  act_o,
   output logic [NUM_CH-1:0]  lvl_o
);
   logic [NUM_REQ-1:0] req_q, req_qq;
   logic [NUM_REQ-1:0] rise;
   logic [CH_W-1:0]    map_tbl [NUM_REQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         req_qq <= '0;
      end else begin
         req_q  <= req_i;
         req_qq <= req_q;
      end
   end

   assign rise     = req_q & ~req_qq;
   assign mirror_o = req_q;

   for (genvar r = 0; r < NUM_REQ; r++) begin : g_map
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            map_tbl[r] <= CH_W'(r % NUM_CH);
         else if (map_wr && (int'(map_idx) == r))
            map_tbl[r] <= map_val;
      end
   end

   always_comb begin
      act_o = '0;
      lvl_o = '0;
      for (int r = 0; r < NUM_REQ; r++) begin
         act_o[map_tbl[r]] = act_o[map_tbl[r]] | rise[r];
         lvl_o[map_tbl[r]] = lvl_o[map_tbl[r]] | req_q[r];
      end
   end

   AST_MIRROR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> mirror_o == $past(req_i)); // R5
endmodule

// File: rtl/dreq_chan_state.sv
module dreq_chan_state #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] act_i,
   input  logic [NUM_CH-1:0] fin_i,
   input  logic [NUM_CH-1:0] err_clr_i,
   input  logic [NUM_CH-1:0] ch_rst_i,
   input  logic              mask_wr,
   input  logic [CH_W-1:0]   mask_idx,
   input  logic              mask_val,
   output logic [NUM_CH-1:0] pend_o,
   output logic [NUM_CH-1:0] err_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] mask_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_o[c] <= 1'b0;
            err_o[c]  <= 1'b0;
            mask_q[c] <= 1'b0;
         end else begin
            if (act_i[c])
               pend_o[c] <= 1'b1;
            else if (fin_i[c] || ch_rst_i[c])
               pend_o[c] <= 1'b0;

            if (act_i[c] && pend_o[c])
               err_o[c] <= 1'b1;
            else if (err_clr_i[c] || ch_rst_i[c])
               err_o[c] <= 1'b0;

            if (mask_wr && (int'(mask_idx) == c))
               mask_q[c] <= mask_val;
         end
      end

      AST_PEND_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         act_i[c] |=> pend_o[c]); // R2
      AST_ERR_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
         act_i[c] && pend_o[c] |=> err_o[c]); // R3
      AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         err_o[c] && !err_clr_i[c] && !ch_rst_i[c] |=> err_o[c]); // R3
   end

   assign irq_o = |(err_o & mask_q);
endmodule

// File: rtl/dreq_engine.sv
module dreq_engine #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2,
   parameter int WM_W   = 4,
   parameter int DEF_WM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pend_i,
   input  logic [NUM_CH-1:0] err_i,
   input  logic [NUM_CH-1:0] lvl_i,
   input  logic              wm_wr,
   input  logic [CH_W-1:0]   wm_idx,
   input  logic [WM_W-1:0]   wm_val,
   input  logic              ack_i,
   output logic              valid_o,
   output logic [CH_W-1:0]   ch_o,
   output logic              done_o,
   output logic [NUM_CH-1:0] fin_o
);
   logic [WM_W-1:0]   wm_tbl [NUM_CH];
   logic              busy;
   logic [CH_W-1:0]   cur;
   logic [WM_W-1:0]   cnt;
   logic [CH_W-1:0]   sel;
   logic              any_ready;
   logic [NUM_CH-1:0] ready;
   logic [WM_W-1:0]   eff_wm;
   logic              last;
   logic              abort;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_wm
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wm_tbl[c] <= WM_W'(DEF_WM);
         else if (wm_wr && (int'(wm_idx) == c))
            wm_tbl[c] <= wm_val;
      end
   end

   assign ready = pend_i & ~err_i;

   always_comb begin
      sel       = '0;
      any_ready = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ready[c]) begin
            sel       = CH_W'(c);
            any_ready = 1'b1;
         end
      end
   end

   assign eff_wm  = (wm_tbl[cur] == '0) ? WM_W'(1) : wm_tbl[cur];
   assign last    = (cnt >= eff_wm - WM_W'(1));
   assign abort   = busy && (!pend_i[cur] || err_i[cur]);
   assign valid_o = busy && !abort;
   assign ch_o    = cur;
   assign done_o  = valid_o && ack_i && last;

   always_comb begin
      fin_o = '0;
      if (done_o && !lvl_i[cur])
         fin_o[cur] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cur  <= '0;
         cnt  <= '0;
      end else if (!busy) begin
         if (any_ready) begin
            busy <= 1'b1;
            cur  <= sel;
            cnt  <= '0;
         end
      end else if (abort) begin
         busy <= 1'b0;
      end else if (ack_i) begin
         if (last) begin
            cnt <= '0;
            if (!lvl_i[cur])
               busy <= 1'b0;
         end else begin
            cnt <= cnt + WM_W'(1);
         end
      end
   end

   AST_STALL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && err_i[cur] |=> !busy); // R7
   AST_FIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fin_o)); // R9
   AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(cur)); // R9
   AST_RECHECK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && lvl_i[cur] |=> busy && $stable(cur)); // R5
endmodule

// File: rtl/dma_req_sched.sv
module dma_req_sched #(
   parameter int NUM_REQ = 4,
   parameter int NUM_CH  = 4,
   parameter int WM_W    = 4,
   parameter int DEF_WM  = 4,
   parameter int CFG_W   = 8,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int MAXN   = (NUM_REQ > NUM_CH) ? NUM_REQ : NUM_CH,
   localparam int IDX_W  = (MAXN > 1) ? $clog2(MAXN) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_i,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_op,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [CFG_W-1:0]   cfg_data,
   output logic [NUM_REQ-1:0] mirror_o,
   output logic [NUM_CH-1:0]  pend_o,
   output logic [NUM_CH-1:0]  err_o,
   output logic               irq_o,
   output logic               xfer_valid_o,
   output logic [CH_W-1:0]    xfer_ch_o,
   input  logic               xfer_ack_i,
   output logic               burst_done_o
);
   import dreq_pkg::*;

   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (NUM_REQ < 1) begin : g_bad_req
      $error("NUM_REQ must be positive");
   end
   if (CFG_W < NUM_CH || CFG_W < WM_W || CFG_W < CH_W) begin : g_bad_cfg
      $error("CFG_W too narrow for channel vectors or watermark");
   end
   if (DEF_WM >= (1 << WM_W)) begin : g_bad_wm
      $error("DEF_WM does not fit in WM_W bits");
   end

   cfg_op_e           op;
   logic              map_wr, wm_wr, mask_wr;
   logic [NUM_CH-1:0] err_clr, ch_rst;
   logic [NUM_CH-1:0] act, lvl, fin;

   assign op      = cfg_op_e'(cfg_op);
   assign map_wr  = cfg_we && (op == CFG_MAP);
   assign wm_wr   = cfg_we && (op == CFG_WM);
   assign mask_wr = cfg_we && (op == CFG_MASK);
   assign err_clr = (cfg_we && op == CFG_ERRCLR) ? cfg_data[NUM_CH-1:0] : '0;
   assign ch_rst  = (cfg_we && op == CFG_CHRST)  ? cfg_data[NUM_CH-1:0] : '0;

   dreq_edge_map #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .CH_W(CH_W), .IDX_W(IDX_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .req_i(req_i),
      .map_wr(map_wr), .map_idx(cfg_idx), .map_val(cfg_data[CH_W-1:0]),
      .mirror_o(mirror_o), .act_o(act), .lvl_o(lvl)
   );

   dreq_chan_state #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_state (
      .clk(clk), .rst_n(rst_n), .act_i(act), .fin_i(fin),
      .err_clr_i(err_clr), .ch_rst_i(ch_rst),
      .mask_wr(mask_wr), .mask_idx(cfg_idx[CH_W-1:0]), .mask_val(cfg_data[0]),
      .pend_o(pend_o), .err_o(err_o), .irq_o(irq_o)
   );

   dreq_engine #(.NUM_CH(NUM_CH), .CH_W(CH_W), .WM_W(WM_W), .DEF_WM(DEF_WM)) u_eng (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_o), .err_i(err_o), .lvl_i(lvl),
      .wm_wr(wm_wr), .wm_idx(cfg_idx[CH_W-1:0]), .wm_val(cfg_data[WM_W-1:0]),
      .ack_i(xfer_ack_i), .valid_o(xfer_valid_o), .ch_o(xfer_ch_o),
      .done_o(burst_done_o), .fin_o(fin)
   );

   AST_IRQ_HAS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (err_o != '0)); // R8
   AST_STALL_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid_o |-> !err_o[xfer_ch_o]); // R7
   AST_DONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done_o |-> xfer_valid_o && xfer_ack_i); // R4
   AST_VALID_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid_o |-> pend_o[xfer_ch_o]); // R2
endmodule

// File: tb/tb_dma_req_sched.sv
`timescale 1ns/1ps
module tb_dma_req_sched;
   localparam int NR = 4;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] req = '0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_op = '0;
   logic [1:0]    cfg_idx = '0;
   logic [7:0]    cfg_data = '0;
   logic [NR-1:0] mirror;
   logic [NC-1:0] pend, err;
   logic          irq, xv, bd;
   logic [1:0]    xch;
   logic          ack = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dma_req_sched dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_we(cfg_we), .cfg_op(cfg_op),
      .cfg_idx(cfg_idx), .cfg_data(cfg_data), .mirror_o(mirror), .pend_o(pend),
      .err_o(err), .irq_o(irq), .xfer_valid_o(xv), .xfer_ch_o(xch),
      .xfer_ack_i(ack), .burst_done_o(bd)
   );

   // line, watermark, bursts to run while the level stays high
   localparam logic [11:0] VEC [4] = '{
      {4'd0, 4'd4, 4'd1},
      {4'd1, 4'd2, 4'd3},
      {4'd2, 4'd0, 4'd2},
      {4'd3, 4'd7, 4'd2}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg(input int op, input int idx, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_op = 3'(op); cfg_idx = 2'(idx); cfg_data = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // raise a line, keep it high for (bursts-1) bursts, drop it before the last
   task automatic run_case(input int line, input int ch, input int eff, input int bursts,
                           output int words, output int nbursts, output int wrong_ch);
      bit dropped = 0;
      words = 0; nbursts = 0; wrong_ch = 0;
      @(negedge clk);
      req[line] = 1'b1;
      for (int cyc = 0; cyc < 600; cyc++) begin
         @(negedge clk);
         if (!dropped && words == (bursts - 1) * eff) begin
            req[line] = 1'b0;
            ack = 1'b0;
            dropped = 1;
            wait_n(3);
            continue;
         end
         if (xv) begin
            if (int'(xch) != ch) wrong_ch++;
            ack = 1'b1;
            words++;
            #1;
            if (bd) nbursts++;
         end else begin
            ack = 1'b0;
         end
         if (dropped && !xv && !pend[ch] && words > 0) break;
      end
      ack = 1'b0;
   endtask

   task automatic serve(input int maxc, output int words, output int first_ch, output int last_ch);
      words = 0; first_ch = -1; last_ch = -1;
      for (int cyc = 0; cyc < maxc; cyc++) begin
         @(negedge clk);
         if (xv) begin
            if (first_ch < 0) first_ch = int'(xch);
            last_ch = int'(xch);
            ack = 1'b1;
            words++;
         end else begin
            ack = 1'b0;
         end
      end
      ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int w, nb, wc, fc, lc, eff;
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);

      // reset state
      check(pend == '0, "R2 reset pend", int'(pend), 0);
      check(err == '0, "R3 reset err", int'(err), 0);
      check(irq == 1'b0, "R8 reset irq", int'(irq), 0);
      check(xv == 1'b0, "R4 reset valid", int'(xv), 0);
      check(mirror == '0, "R5 reset mirror", int'(mirror), 0);

      // table walk: default map line r -> channel r
      for (int i = 0; i < 4; i++) begin
         int line, wm, nbur;
         line = int'(VEC[i][11:8]);
         wm   = int'(VEC[i][7:4]);
         nbur = int'(VEC[i][3:0]);
         eff  = (wm == 0) ? 1 : wm;
         cfg(1, line, wm);
         run_case(line, line, eff, nbur, w, nb, wc);
         check(w == eff * nbur, "R4 R5 words per case", w, eff * nbur);
         check(nb == nbur, "R5 burst count", nb, nbur);
         check(wc == 0, "R6 default map channel", wc, 0);
         check(pend[line] == 1'b0, "R2 pend cleared", int'(pend[line]), 0);
         check(err == '0, "R3 no error", int'(err), 0);
      end

      // R6: remap line 2 to channel 0 (watermark 4)
      cfg(0, 2, 0);
      run_case(2, 0, 4, 1, w, nb, wc);
      check(w == 4, "R6 remapped words", w, 4);
      check(wc == 0, "R6 remapped channel", wc, 0);
      cfg(0, 2, 2);

      // R1 and R10: steady level after channel reset does not reactivate
      @(negedge clk); req[0] = 1'b1;
      wait_n(4);
      check(pend[0] == 1'b1, "R2 pend set", int'(pend[0]), 1);
      cfg(4, 0, 1);
      wait_n(10);
      check(pend[0] == 1'b0, "R1 R10 level no reactivate", int'(pend[0]), 0);
      check(xv == 1'b0, "R10 burst ended", int'(xv), 0);
      req[0] = 1'b0;
      wait_n(3);

      // R3 R7 R8: repeat edge while pending, mask on
      cfg(2, 1, 1);
      @(negedge clk); req[1] = 1'b1;
      wait_n(4);
      check(mirror[1] == 1'b1, "R5 mirror high", int'(mirror[1]), 1);
      req[1] = 1'b0; wait_n(2);
      check(mirror[1] == 1'b0, "R5 mirror low", int'(mirror[1]), 0);
      req[1] = 1'b1; wait_n(3);
      check(err[1] == 1'b1, "R3 error on repeat edge", int'(err[1]), 1);
      check(irq == 1'b1, "R8 irq masked in", int'(irq), 1);
      check(xv == 1'b0, "R7 stalled no valid", int'(xv), 0);
      wait_n(5);
      check(xv == 1'b0 && pend[1], "R7 still stalled and pending", int'(xv), 0);
      req[1] = 1'b0; wait_n(3);
      cfg(3, 0, 2);
      check(err[1] == 1'b0 && irq == 1'b0, "R7 R8 cleared", int'(err[1]), 0);
      serve(20, w, fc, lc);
      check(w == 2, "R7 resumed words", w, 2);
      check(fc == 1, "R7 resumed channel", fc, 1);
      check(pend[1] == 1'b0, "R2 resumed finish", int'(pend[1]), 0);

      // R8: mask off, error present, no irq; then R10 reset
      cfg(2, 1, 0);
      @(negedge clk); req[1] = 1'b1;
      wait_n(4);
      req[1] = 1'b0; wait_n(2);
      req[1] = 1'b1; wait_n(3);
      check(err[1] == 1'b1, "R3 error again", int'(err[1]), 1);
      check(irq == 1'b0, "R8 irq masked out", int'(irq), 0);
      req[1] = 1'b0; wait_n(3);
      cfg(4, 0, 2);
      check(pend[1] == 1'b0 && err[1] == 1'b0, "R10 channel reset", int'({pend[1], err[1]}), 0);

      // R9: channels 1 and 3 requested together
      cfg(1, 1, 1);
      cfg(1, 3, 1);
      @(negedge clk); req[1] = 1'b1; req[3] = 1'b1;
      wait_n(4);
      check(mirror == 4'b1010, "R5 mirror pattern", int'(mirror), 10);
      check(xv && xch == 2'd3, "R9 highest first", int'(xch), 3);
      req[1] = 1'b0; req[3] = 1'b0;
      wait_n(3);
      serve(20, w, fc, lc);
      check(fc == 3 && lc == 1, "R9 order 3 then 1", fc * 10 + lc, 31);
      check(w == 2, "R9 total words", w, 2);
      check(pend == '0, "R9 all finished", int'(pend), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule